// File: doc/BRIEF.md
# Turn-signal tail-light sequencer

This block drives the tail lamps of a vehicle: three lamps on the left side and three on the right. It has three request inputs: turn left, turn right and hazard. Each enabled clock edge is one flash step. A turn request lights its side from the inside outward, one lamp per step, over three steps, and then that side goes dark for one step. A hazard request, or left and right requested together, lights all six lamps for one step, and the next step returns to dark.

The machine keeps eight states in a three-bit register. Two bits count the turn step in a Gray sequence, and the third bit selects the side. The code with the side bit set and the count at zero is used for the all-lamps step. The step-enable input lets a fast system clock drive the block. The state moves only on edges where the enable is high, so the enable pulse rate sets the flash rate.

Top module: `taillight_seq`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) puts the block in the dark state, with lamp_l = 000 and lamp_r = 000 after that edge, whatever the other inputs are.
- R2: From the dark state, with hazard low: turn_l alone gives lamp_l = 001, lamp_r = 000 after the next enabled edge; turn_r alone gives lamp_r = 001, lamp_l = 000; no request keeps all lamps off.
- R3: From the dark state, hazard high, or turn_l and turn_r both high, gives lamp_l = lamp_r = 111 after the next enabled edge. Lamps on both sides are only ever lit together when all six are lit.
- R4: A left sequence shows lamp_l = 001, 011, 111 on successive enabled steps, with lamp_r = 000 throughout. Bit 0 is the innermost lamp and bit 2 the outermost.
- R5: A right sequence shows lamp_r = 001, 011, 111 on successive enabled steps, with lamp_l = 000 throughout. The bit order is the same as for the left side.
- R6: Hazard high during the first or second step of either turn sequence gives all six lamps lit at the next enabled step.
- R7: After the third turn step or the all-lamps step, the next enabled edge always goes to dark, whatever the request inputs are.
- R8: Once a turn sequence has started, turn_l and turn_r have no effect on it. Only hazard can change its course.
- R9: An edge with step_en low leaves the state and both lamp outputs unchanged.
- R10: During a turn sequence the two step bits change by exactly one bit per step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Flash-step enable; the state advances only when it is high |
| turn_l | input | 1 | Left turn request |
| turn_r | input | 1 | Right turn request |
| hazard | input | 1 | Hazard request |
| lamp_l | output | 3 | Left lamps, bit 0 innermost |
| lamp_r | output | 3 | Right lamps, bit 0 innermost |

## Verification
The hardest cases to reach are a hazard arriving in the middle of a turn sequence, and a stalled step landing in the middle or at the tail of a sequence. Both need the machine steered into a particular state first. The bench resets and then drives a fixed prefix to each of the eight states. From each state it applies all sixteen combinations of enable and the three requests. After that, a long pseudo-random run with occasional resets and stalls covers chains of such events.

// File: rtl/tl_pkg.sv
package tl_pkg;
    localparam int SIDE_LAMPS = 3;
    localparam int STATE_W    = 3;

    // bit 2: right side; bits 1:0: Gray step count (00 with bit 2 set = all lamps)
    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 3'b000,
        ST_L1   = 3'b001,
        ST_L2   = 3'b011,
        ST_L3   = 3'b010,
        ST_R1   = 3'b101,
        ST_R2   = 3'b111,
        ST_R3   = 3'b110,
        ST_ALL  = 3'b100
    } tl_state_e;

    typedef struct packed {
        tl_state_e state;
    } tl_regs_t;
endpackage

// File: rtl/tl_next.sv
module tl_next
    import tl_pkg::*;
(
    input  tl_state_e cur,
    input  logic      go_l,
    input  logic      go_r,
    input  logic      haz,
    output tl_state_e nxt
);
    always_comb begin
        nxt = ST_IDLE;
        case (cur)
            ST_IDLE: begin
                if (haz || (go_l && go_r)) nxt = ST_ALL;
                else if (go_l)             nxt = ST_L1;
                else if (go_r)             nxt = ST_R1;
                else                       nxt = ST_IDLE;
            end
            ST_L1:   nxt = haz ? ST_ALL : ST_L2;
            ST_L2:   nxt = haz ? ST_ALL : ST_L3;
            ST_R1:   nxt = haz ? ST_ALL : ST_R2;
            ST_R2:   nxt = haz ? ST_ALL : ST_R3;
            default: nxt = ST_IDLE; // L3, R3, ALL
        endcase
    end
endmodule

// File: rtl/tl_lamps.sv
module tl_lamps
    import tl_pkg::*;
(
    input  tl_state_e             st,
    output logic [SIDE_LAMPS-1:0] lamp_l,
    output logic [SIDE_LAMPS-1:0] lamp_r
);
    logic [1:0] pos;
    logic       all_on;

    always_comb begin
        case (st[1:0])
            2'b01:   pos = 2'd1;
            2'b11:   pos = 2'd2;
            2'b10:   pos = 2'd3;
            default: pos = 2'd0;
        endcase
        all_on = (st == ST_ALL);
    end

    for (genvar i = 0; i < SIDE_LAMPS; i++) begin : g_lamp
        assign lamp_l[i] = all_on || (!st[2] && (pos > 2'(i)));
        assign lamp_r[i] = all_on || ( st[2] && (pos > 2'(i)));
    end
endmodule

// File: rtl/taillight_seq.sv
module taillight_seq
    import tl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  step_en,
    input  logic                  turn_l,
    input  logic                  turn_r,
    input  logic                  hazard,
    output logic [SIDE_LAMPS-1:0] lamp_l,
    output logic [SIDE_LAMPS-1:0] lamp_r
);
    tl_regs_t  regs_d, regs_q;
    tl_state_e nxt_state;

    tl_next u_next (
        .cur  (regs_q.state),
        .go_l (turn_l),
        .go_r (turn_r),
        .haz  (hazard),
        .nxt  (nxt_state)
    );

    always_comb begin
        regs_d = regs_q;
        if (step_en) regs_d.state = nxt_state;
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q.state <= ST_IDLE;
        else     regs_q <= regs_d;
    end

    tl_lamps u_lamps (
        .st     (regs_q.state),
        .lamp_l (lamp_l),
        .lamp_r (lamp_r)
    );

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(regs_q.state));

    p_tail_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (step_en && (regs_q.state == ST_L3 || regs_q.state == ST_R3 || regs_q.state == ST_ALL))
        |=> regs_q.state == ST_IDLE);

    p_hazard_cut_r6: assert property (@(posedge clk) disable iff (rst)
        (step_en && hazard && (regs_q.state == ST_L1 || regs_q.state == ST_L2 ||
                               regs_q.state == ST_R1 || regs_q.state == ST_R2))
        |=> regs_q.state == ST_ALL);

    p_gray_step_r10: assert property (@(posedge clk) disable iff (rst)
        (step_en && !hazard && (regs_q.state == ST_L1 || regs_q.state == ST_L2 ||
                                regs_q.state == ST_R1 || regs_q.state == ST_R2))
        |=> $countones(regs_q.state[1:0] ^ $past(regs_q.state[1:0])) == 1);

    p_sides_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        ((|lamp_l) && (|lamp_r)) |-> ((&lamp_l) && (&lamp_r)));
endmodule

// File: tb/sim_taillight_seq.sv
module sim_taillight_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1, step_en = 1'b0, turn_l = 1'b0, turn_r = 1'b0, hazard = 1'b0;
    logic [2:0] lamp_l, lamp_r;

    int n_tests = 0;
    int n_fail  = 0;
    int m_kind  = 0; // 0 dark, 1 left, 2 right, 3 all
    int m_step  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    taillight_seq u0 (
        .clk(clk), .rst(rst), .step_en(step_en), .turn_l(turn_l),
        .turn_r(turn_r), .hazard(hazard), .lamp_l(lamp_l), .lamp_r(lamp_r)
    );

    task automatic check(string tag);
        logic [2:0] el, er;
        el = 3'b000; er = 3'b000;
        if (m_kind == 1) el = 3'((1 << m_step) - 1);
        if (m_kind == 2) er = 3'((1 << m_step) - 1);
        if (m_kind == 3) begin el = 3'b111; er = 3'b111; end
        n_tests++;
        if (lamp_l !== el || lamp_r !== er) begin
            n_fail++;
            $display("FAIL %s: lamp_l=%b lamp_r=%b expected lamp_l=%b lamp_r=%b",
                     tag, lamp_l, lamp_r, el, er);
        end
    endtask

    task automatic cyc(bit r, bit en, bit l, bit rr, bit h);
        string tag;
        @(negedge clk);
        rst = r; step_en = en; turn_l = l; turn_r = rr; hazard = h;
        @(posedge clk);
        #1;
        if (r) begin
            tag = "R1"; m_kind = 0; m_step = 0;
        end else if (!en) begin
            tag = "R9";
        end else if (m_kind == 0) begin
            if (h || (l && rr)) begin tag = "R3"; m_kind = 3; end
            else if (l)         begin tag = "R2"; m_kind = 1; m_step = 1; end
            else if (rr)        begin tag = "R2"; m_kind = 2; m_step = 1; end
            else                       tag = "R2";
        end else if (m_kind == 3 || m_step == 3) begin
            tag = "R7"; m_kind = 0; m_step = 0;
        end else if (h) begin
            tag = "R6"; m_kind = 3; m_step = 0;
        end else begin
            if (m_kind == 1) tag = (!l || rr) ? "R8" : "R4";
            else             tag = (!rr || l) ? "R8" : "R5";
            m_step++;
        end
        check(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        // R1: reset state
        cyc(1, 1, 1, 1, 1);
        // R4 R5 R6 R7 R8 R9 R2 R3: every state x every enable/request combination
        for (int target = 0; target < 8; target++) begin
            for (int combo = 0; combo < 16; combo++) begin
                cyc(1, 0, 0, 0, 0);
                if (target >= 1 && target <= 3)
                    for (int k = 0; k < target; k++) cyc(0, 1, 1, 0, 0);
                else if (target >= 4 && target <= 6)
                    for (int k = 0; k < target - 3; k++) cyc(0, 1, 0, 1, 0);
                else if (target == 7)
                    cyc(0, 1, 0, 0, 1);
                cyc(0, combo[3], combo[2], combo[1], combo[0]);
                cyc(0, 1, 0, 0, 0);
            end
        end
        // long pseudo-random run with stalls and rare resets
        lfsr = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[8:4] == 5'd0, lfsr[0] | lfsr[1], lfsr[2],
                lfsr[3], lfsr[5] & lfsr[6] & lfsr[7]);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule